// File: doc/BRIEF.md
# Dual-Axis Scanner Serial Transmitter

This block streams position words for two scanner axes over a synchronous serial link without a break. It divides the system clock into a free-running link clock with a 50% duty cycle. It drives one frame marker line and two data lines, one for each axis. Both data lines carry their frames at the same time and share the clock and the marker.

Every frame is twenty link-clock periods long and starts as soon as the previous frame ends. A frame carries a fixed three-bit preamble, then a sixteen-bit position word sent most significant bit first, then an even-parity bit.

The host writes new positions into two holding registers with a load strobe. The block copies the holding registers into the transmit shifters only at the start of a frame. It raises a single-cycle request at each frame start, which tells the host that the next words can be written.

Top module: `scan_link_tx`

## Requirements
- R1: Each high phase and each low phase of `link_clk` lasts `div_half` system clocks, so the divide ratio is always `2*div_half` and therefore even. A `div_half` of 0 acts as 1. The link clock never pauses.
- R2: Frames are 20 link-clock periods long and follow each other with no gap. The rising link edge that starts a frame comes one full link period after the rising edge that carried bit 19 of the previous frame.
- R3: Within a frame, bit positions 0, 1 and 2 carry 0, 0 and 1. Positions 3 to 18 carry the position word, most significant bit first. Position 19 is chosen so that the frame holds an even number of ones.
- R4: The data lines change only on the system edge on which `link_clk` rises.
- R5: `link_sync` rises together with the first rising link edge of a frame, stays high for bit positions 0 to 18, and is low during bit position 19.
- R6: The X frame and the Y frame are sent at the same time on `link_dx` and `link_dy`, each from its own position word.
- R7: A `host_load` pulse copies `pos_x` and `pos_y` into the holding registers. A frame sends the values that the holding registers held before the system edge that starts it. A load during a frame, or on the edge that starts a frame, only affects the following frame.
- R8: `req` is high for exactly one system cycle, on the system edge that starts each frame.
- R9: During reset and after it, `link_clk`, `link_sync`, `link_dx`, `link_dy` and `req` are low and both holding registers hold 0x8000. The first frame starts `div_half` system clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_half | input | DIV_W | Link clock half period in system clocks (0 acts as 1) |
| host_load | input | 1 | Copies pos_x and pos_y into the holding registers |
| pos_x | input | DATA_W | X axis position word |
| pos_y | input | DATA_W | Y axis position word |
| req | output | 1 | One-cycle pulse at each frame start |
| link_clk | output | 1 | Link clock, 50% duty |
| link_sync | output | 1 | Frame marker |
| link_dx | output | 1 | X axis serial data |
| link_dy | output | 1 | Y axis serial data |

## Verification
The bench uses the default widths: 16-bit words and an 8-bit divider field. It sets `div_half` to 2 for the main scenarios, then resets the block with 1, 3 and 0. A value of 1 gives the tightest timing, where the request and the frame start sit only two system cycles after the last bit edge. A value of 3 gives odd-length phases. A value of 0 exercises the clamp to 1. These settings make it possible to check the phase lengths, the gapless hand-over from one frame to the next, and a load that lands exactly on the frame-start edge, all within a few hundred cycles.

// File: rtl/scan_link_pkg.sv
package scan_link_pkg;
  localparam int unsigned HDR_W = 3;
  localparam logic [HDR_W-1:0] HDR_BITS = 3'b001;
  localparam int unsigned TAIL_W = 1;

  typedef enum logic {
    SEQ_WAIT = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/scan_link_clkgen.sv
module scan_link_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_half,
  output logic             link_clk,
  output logic             rise_en
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] last;
  logic             tick;

  assign lim     = (div_half == '0) ? DIV_W'(1) : div_half;
  assign last    = lim - DIV_W'(1);
  assign tick    = (cnt >= last);
  assign rise_en = tick && !link_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      link_clk <= 1'b0;
    end else if (tick) begin
      cnt      <= '0;
      link_clk <= ~link_clk;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  a_r1_rise_follows_enable: assert property (@(posedge clk) disable iff (rst)
    rise_en |=> $rose(link_clk));
endmodule

// File: rtl/scan_link_seq.sv
module scan_link_seq
  import scan_link_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_en,
  output logic load_frame,
  output logic shift_en,
  output logic link_sync,
  output logic req
);
  localparam int unsigned IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic             wrap;

  assign wrap       = (state == SEQ_WAIT) || (idx == LAST);
  assign load_frame = rise_en && wrap;
  assign shift_en   = rise_en && !wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_WAIT;
      idx       <= '0;
      link_sync <= 1'b0;
      req       <= 1'b0;
    end else begin
      req <= load_frame;
      if (load_frame) begin
        state     <= SEQ_RUN;
        idx       <= '0;
        link_sync <= 1'b1;
      end else if (shift_en) begin
        idx       <= idx + IDX_W'(1);
        link_sync <= ((idx + IDX_W'(1)) != LAST);
      end
    end
  end

  a_r2_index_in_range: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST);
  a_r2_run_never_leaves: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_RUN) |=> (state == SEQ_RUN));
endmodule

// File: rtl/scan_link_lane.sv
module scan_link_lane
  import scan_link_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_load,
  input  logic [DATA_W-1:0] pos_in,
  input  logic              load_frame,
  input  logic              shift_en,
  output logic              dout
);
  localparam int unsigned FRAME_LEN = HDR_W + DATA_W + TAIL_W;
  localparam logic [DATA_W-1:0] MID_SCALE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0]    hold;
  logic [FRAME_LEN-1:0] shreg;
  logic [FRAME_LEN-2:0] body;
  logic [FRAME_LEN-1:0] word;

  assign body = {HDR_BITS, hold};
  assign word = {body, ^body};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= MID_SCALE;
    end else if (host_load) begin
      hold <= pos_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      dout  <= 1'b0;
    end else if (load_frame) begin
      dout  <= word[FRAME_LEN-1];
      shreg <= {word[FRAME_LEN-2:0], 1'b0};
    end else if (shift_en) begin
      dout  <= shreg[FRAME_LEN-1];
      shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
    end
  end

  a_r3_preamble_leads: assert property (@(posedge clk) disable iff (rst)
    load_frame |=> (dout == HDR_BITS[HDR_W-1]));
  a_r4_quiet_between_edges: assert property (@(posedge clk) disable iff (rst)
    !(load_frame || shift_en) |=> $stable(dout));
endmodule

// File: rtl/scan_link_tx.sv
module scan_link_tx
  import scan_link_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              host_load,
  input  logic [DATA_W-1:0] pos_x,
  input  logic [DATA_W-1:0] pos_y,
  output logic              req,
  output logic              link_clk,
  output logic              link_sync,
  output logic              link_dx,
  output logic              link_dy
);
  localparam int unsigned FRAME_LEN = HDR_W + DATA_W + TAIL_W;
  localparam int unsigned N_AXES = 2;

  logic rise_en;
  logic load_frame;
  logic shift_en;
  logic [DATA_W-1:0] pos_arr [N_AXES];
  logic [N_AXES-1:0] dout_arr;

  assign pos_arr[0] = pos_x;
  assign pos_arr[1] = pos_y;
  assign link_dx    = dout_arr[0];
  assign link_dy    = dout_arr[1];

  scan_link_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .div_half (div_half),
    .link_clk (link_clk),
    .rise_en  (rise_en)
  );

  scan_link_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .rise_en    (rise_en),
    .load_frame (load_frame),
    .shift_en   (shift_en),
    .link_sync  (link_sync),
    .req        (req)
  );

  for (genvar a = 0; a < N_AXES; a++) begin : g_lane
    scan_link_lane #(.DATA_W(DATA_W)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .host_load  (host_load),
      .pos_in     (pos_arr[a]),
      .load_frame (load_frame),
      .shift_en   (shift_en),
      .dout       (dout_arr[a])
    );
  end

  a_r4_dx_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
    (link_dx != $past(link_dx)) |-> $rose(link_clk));
  a_r4_dy_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
    (link_dy != $past(link_dy)) |-> $rose(link_clk));
  a_r5_sync_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
    (link_sync != $past(link_sync)) |-> $rose(link_clk));
  a_r8_req_single_cycle: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
  a_r8_req_marks_frame: assert property (@(posedge clk) disable iff (rst)
    req |-> $rose(link_sync));
endmodule

// File: tb/test_scan_link_tx.sv
module test_scan_link_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  div_half = 8'd2;
  logic        host_load = 1'b0;
  logic [15:0] pos_x = '0;
  logic [15:0] pos_y = '0;
  logic        req, link_clk, link_sync, link_dx, link_dy;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  always #10 clk = ~clk;

  scan_link_tx i_scan_link_tx (
    .clk(clk), .rst(rst), .div_half(div_half), .host_load(host_load),
    .pos_x(pos_x), .pos_y(pos_y), .req(req), .link_clk(link_clk),
    .link_sync(link_sync), .link_dx(link_dx), .link_dy(link_dy)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nerr++;
      $display("FAIL R2 watchdog expired actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [19:0] exp_word(input logic [15:0] d);
    logic [18:0] h;
    h = {3'b001, d};
    return {h, ^h};
  endfunction

  // R9: reset state, then first rise after div_half clocks
  task automatic do_reset(input logic [7:0] dh_raw, input int dh);
    int n;
    div_half  = dh_raw;
    rst       = 1'b1;
    host_load = 1'b0;
    repeat (4) step();
    chk({link_clk, link_sync, link_dx, link_dy, req} == 5'b0, "R9",
        {link_clk, link_sync, link_dx, link_dy, req}, 0);
    rst = 1'b0;
    n = 0;
    do begin
      step();
      n++;
    end while (!link_clk && n < 100);
    chk(n == dh, "R9", n, dh);
    chk(req === 1'b1 && link_sync === 1'b1, "R8", {req, link_sync}, 2'b11);
  endtask

  // Starts at the negedge where req is seen; records 20 bits (R1 R4 R5 R8)
  task automatic grab_frame(input int dh, input bit do_load, input logic [15:0] lx,
                            input logic [15:0] ly, output logic [19:0] fx,
                            output logic [19:0] fy, output logic [19:0] fs);
    logic pc, pdx, pdy;
    fx[19] = link_dx; fy[19] = link_dy; fs[19] = link_sync;
    for (int b = 1; b < 20; b++) begin
      int n;
      bit done;
      n = 0;
      done = 0;
      while (!done) begin
        pc = link_clk; pdx = link_dx; pdy = link_dy;
        step();
        n++;
        if (do_load && b == 6 && n == 1) begin
          host_load = 1'b1; pos_x = lx; pos_y = ly;
        end else begin
          host_load = 1'b0;
        end
        if (b == 1 && n == 1) chk(req === 1'b0, "R8", req, 0);
        if (!pc && link_clk) begin
          chk(n == 2 * dh, "R1", n, 2 * dh);
          done = 1;
        end else begin
          if (pc && !link_clk) chk(n == dh, "R1", n, dh);
          chk(link_dx === pdx && link_dy === pdy, "R4", {link_dx, link_dy}, {pdx, pdy});
        end
        if (n > 4 * dh + 4) begin
          chk(0, "R1", n, 2 * dh);
          done = 1;
        end
      end
      fx[19-b] = link_dx; fy[19-b] = link_dy; fs[19-b] = link_sync;
    end
    host_load = 1'b0;
  endtask

  // R2: next frame starts one link period after bit 19
  task automatic next_frame(input int dh);
    int n;
    n = 0;
    do begin
      step();
      n++;
    end while (!req && n < 1000);
    chk(n == 2 * dh, "R2", n, 2 * dh);
  endtask

  task automatic check_frame(input logic [19:0] fx, input logic [19:0] fy,
                             input logic [19:0] fs, input logic [15:0] ex,
                             input logic [15:0] ey);
    chk(fx == exp_word(ex), "R3", fx, exp_word(ex));
    chk(fy == exp_word(ey), "R6", fy, exp_word(ey));
    chk(fs == 20'hFFFFE, "R5", fs, 20'hFFFFE);
  endtask

  task automatic t_reset_midscale(input logic [7:0] dh_raw, input int dh);
    logic [19:0] fx, fy, fs;
    do_reset(dh_raw, dh);
    grab_frame(dh, 1'b1, 16'h1234, 16'hA5C3, fx, fy, fs);
    check_frame(fx, fy, fs, 16'h8000, 16'h8000);      // R9 mid-scale, R7 load mid-frame ignored
    next_frame(dh);
    grab_frame(dh, 1'b0, 16'h0, 16'h0, fx, fy, fs);
    check_frame(fx, fy, fs, 16'h1234, 16'hA5C3);      // R7 new values in next frame
  endtask

  task automatic t_parity_set(input int dh);
    logic [19:0] fx, fy, fs;
    logic [15:0] vx [5];
    logic [15:0] vy [5];
    vx = '{16'h0000, 16'hFFFF, 16'h0001, 16'h7FFF, 16'hC3A5};
    vy = '{16'hFFFF, 16'h0001, 16'h0000, 16'h8001, 16'h5A5A};
    next_frame(dh);
    grab_frame(dh, 1'b1, vx[0], vy[0], fx, fy, fs);
    for (int i = 0; i < 5; i++) begin
      next_frame(dh);
      if (i < 4) grab_frame(dh, 1'b1, vx[i+1], vy[i+1], fx, fy, fs);
      else       grab_frame(dh, 1'b0, 16'h0, 16'h0, fx, fy, fs);
      check_frame(fx, fy, fs, vx[i], vy[i]);         // R3 parity patterns
    end
  endtask

  // R7: load on the very edge that starts a frame only reaches the next frame
  task automatic t_load_at_start(input int dh);
    logic [19:0] fx, fy, fs;
    next_frame(dh);
    repeat (40 * dh - 1) step();
    host_load = 1'b1; pos_x = 16'hBEEF; pos_y = 16'h0F0F;
    step();
    host_load = 1'b0;
    chk(req === 1'b1, "R7", req, 1);
    grab_frame(dh, 1'b0, 16'h0, 16'h0, fx, fy, fs);
    check_frame(fx, fy, fs, 16'h5A5A ^ 16'h5A5A ^ 16'hC3A5, 16'h5A5A);
    next_frame(dh);
    grab_frame(dh, 1'b0, 16'h0, 16'h0, fx, fy, fs);
    check_frame(fx, fy, fs, 16'hBEEF, 16'h0F0F);
  endtask

  initial begin
    t_reset_midscale(8'd2, 2);
    t_parity_set(2);
    t_load_at_start(2);
    t_reset_midscale(8'd1, 1);   // R1 tightest ratio
    t_reset_midscale(8'd3, 3);   // R1 odd half period
    t_reset_midscale(8'd0, 1);   // R1 zero acts as one
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule